// File: doc/BRIEF.md
# Segment Descriptor Load Unit

This block serves a write of a 16-bit selector into one of several data segment registers. It splits the selector into a table index, a table-choice bit and a requester level. It works out the byte address of the 8-byte descriptor in the chosen table and checks that the whole descriptor fits under the table limit. It then fetches the descriptor as four 16-bit reads over a simple request/acknowledge read port. The unit checks the descriptor's type, privilege and presence, and on success places base, limit and access byte in a hidden per-segment cache. Later accesses use that cache without going back to the table.

A load starts when `ld_valid` is high while `ld_ready` is high. Every load ends with a one-cycle `done` pulse. `fault` marks a rejected load and `fault_np` marks the not-present case. A null selector is accepted but leaves the entry marked invalid, and `use_fault` reports this for the segment named on `use_seg`. Writing the selector that an entry already holds completes without any memory traffic.

Top module: `seg_desc_loader`

## Requirements
- R1: Selector bits 15:3 are the index, bit 2 chooses the table (0 = global, 1 = local) and bits 1:0 play no part in the lookup. The descriptor byte address is the chosen table base plus index times 8.
- R2: A fetch issues exactly four 16-bit reads in this order, at descriptor address +0, +2, +4 and +6. Word 0 is the limit. Word 1 is base bits 15:0. In word 2, bits 7:0 are base bits 23:16 and bits 15:8 are the access byte. Word 3 is discarded. While `mem_ack` is low, `mem_req` and `mem_addr` hold.
- R3: If index*8+7 is greater than the chosen table limit, the load ends one cycle after acceptance with `fault`=1 and `fault_np`=0, and no memory read is made.
- R4: A selector with bits 15:2 all zero is a null load. It ends one cycle after acceptance without fault and without reads, clears the entry's valid bit, and `use_fault` is then 1 for that segment.
- R5: An access byte with bit 4 = 0 (system type), or with bit 3 = 1 and bit 1 = 0 (execute-only code), gives a general fault (`fault`=1, `fault_np`=0).
- R6: If the descriptor level in access bits 6:5 is numerically lower than `cpl`, the load gives a general fault.
- R7: If R5 and R6 pass and access bit 7 (present) is 0, the load faults with `fault_np`=1. R5 and R6 take priority over this case.
- R8: A load that passes all checks writes base, limit and access byte into the target entry and sets its valid bit. It then ends with `done`=1 and `fault`=0.
- R9: A faulting load leaves every cache entry unchanged.
- R10: Loading the selector that a valid entry already holds ends one cycle after acceptance with no reads and no change to the entry, even if table memory has changed.
- R11: After reset all entries are invalid and zero, `done`, `fault` and `mem_req` are low, and `ld_ready` is high.
- R12: While a fetch is in progress, `ld_ready` is low and `ld_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Selector write request |
| ld_ready | output | 1 | Unit can accept a request |
| ld_sel | input | 16 | Selector value |
| ld_seg | input | SEG_W | Target segment register |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | 16 | Global table limit |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_limit | input | 16 | Local table limit |
| mem_req | output | 1 | Word read request |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_rdata | input | 16 | Read data, valid with ack |
| mem_ack | input | 1 | Read completes this cycle |
| done | output | 1 | Load finished (pulse) |
| fault | output | 1 | Load rejected (pulse with done) |
| fault_np | output | 1 | Rejected as not present |
| use_seg | input | SEG_W | Segment being used |
| use_fault | output | 1 | That segment holds no valid descriptor |
| seg_valid | output | NUM_SEG | Entry valid bits |
| seg_base | output | NUM_SEG*24 | Cached bases, entry i at bits 24i+23:24i |
| seg_limit | output | NUM_SEG*16 | Cached limits |
| seg_ar | output | NUM_SEG*8 | Cached access bytes |

## Verification
The hardest case to reach is a second request that arrives while a fetch is stalled by a slow memory. The stimulus throttles `mem_ack` and keeps `ld_valid` high with another selector and segment across the fetch. It then confirms that only the first load reached the cache. Priority between type, privilege and presence faults is covered by a sweep over every access-byte pattern against every current level, with the outcome computed from the rules above. Table-limit edges are approached from both sides on both tables.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
   localparam int DBASE_W = 24;
   localparam int DLIM_W  = 16;
   localparam int SEL_W   = 16;

   typedef enum logic [2:0] {
      ST_IDLE, ST_W0, ST_W1, ST_W2, ST_W3, ST_CHK
   } fetch_st_t;

   typedef enum logic [1:0] {
      RES_OK, RES_GP, RES_NP
   } load_res_t;

   // access byte, most significant bit first
   typedef struct packed {
      logic       present;
      logic [1:0] dpl;
      logic       app_type;
      logic       exec;
      logic       dir_conf;
      logic       wr_rd;
      logic       touched;
   } acc_byte_t;

   function automatic load_res_t judge_desc(input acc_byte_t ab, input logic [1:0] lvl);
      logic bad_type;
      bad_type = !ab.app_type || (ab.exec && !ab.wr_rd);
      if (bad_type || (ab.dpl < lvl))
         return RES_GP;
      else if (!ab.present)
         return RES_NP;
      else
         return RES_OK;
   endfunction
endpackage

// File: rtl/sdl_sel_decode.sv
module sdl_sel_decode #(
   parameter int ADDR_W = 24
) (
   input  logic [12:0]       idx,
   input  logic              ti,
   input  logic [ADDR_W-1:0] gdt_base,
   input  logic [15:0]       gdt_limit,
   input  logic [ADDR_W-1:0] ldt_base,
   input  logic [15:0]       ldt_limit,
   output logic              is_null,
   output logic              over_limit,
   output logic [ADDR_W-1:0] desc_addr
);
   localparam int OFF_W = 16;

   logic [OFF_W-1:0] offset;
   logic [OFF_W:0]   last_byte;
   logic [15:0]      tbl_limit;
   logic [ADDR_W-1:0] tbl_base;

   always_comb begin
      offset     = {idx, 3'b000};
      last_byte  = {1'b0, offset} + 17'd7;
      tbl_limit  = ti ? ldt_limit : gdt_limit;
      tbl_base   = ti ? ldt_base  : gdt_base;
      over_limit = last_byte > {1'b0, tbl_limit};
      is_null    = (idx == 13'd0) && !ti;
      desc_addr  = tbl_base + ADDR_W'(offset);
   end
endmodule

// File: rtl/sdl_fetch_fsm.sv
module sdl_fetch_fsm
   import sdl_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  start_addr,
   input  logic [1:0]         start_cpl,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic [15:0]        mem_rdata,
   input  logic               mem_ack,
   output logic               busy,
   output logic               fin,
   output load_res_t          fin_res,
   output logic [DBASE_W-1:0] d_base,
   output logic [DLIM_W-1:0]  d_limit,
   output acc_byte_t          d_ar
);
   fetch_st_t         st, st_nx;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        cpl_q;
   logic [15:0]       lim_q;
   logic [15:0]       blo_q;
   logic [7:0]        bhi_q;
   acc_byte_t         ar_q;
   logic [3:0]        word_off;

   always_comb begin
      mem_req  = 1'b0;
      word_off = 4'd0;
      unique case (st)
         ST_W0: begin mem_req = 1'b1; word_off = 4'd0; end
         ST_W1: begin mem_req = 1'b1; word_off = 4'd2; end
         ST_W2: begin mem_req = 1'b1; word_off = 4'd4; end
         ST_W3: begin mem_req = 1'b1; word_off = 4'd6; end
         default: ;
      endcase
      mem_addr = addr_q + ADDR_W'(word_off);
   end

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: if (start)   st_nx = ST_W0;
         ST_W0:   if (mem_ack) st_nx = ST_W1;
         ST_W1:   if (mem_ack) st_nx = ST_W2;
         ST_W2:   if (mem_ack) st_nx = ST_W3;
         ST_W3:   if (mem_ack) st_nx = ST_CHK;
         ST_CHK:               st_nx = ST_IDLE;
         default:              st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         addr_q <= '0;
         cpl_q  <= '0;
         lim_q  <= '0;
         blo_q  <= '0;
         bhi_q  <= '0;
         ar_q   <= '0;
      end else begin
         st <= st_nx;
         if (st == ST_IDLE && start) begin
            addr_q <= start_addr;
            cpl_q  <= start_cpl;
         end
         if (mem_ack) begin
            unique case (st)
               ST_W0: lim_q <= mem_rdata;
               ST_W1: blo_q <= mem_rdata;
               ST_W2: begin
                  bhi_q <= mem_rdata[7:0];
                  ar_q  <= acc_byte_t'(mem_rdata[15:8]);
               end
               default: ;
            endcase
         end
      end
   end

   assign busy    = (st != ST_IDLE);
   assign fin     = (st == ST_CHK);
   assign fin_res = judge_desc(ar_q, cpl_q);
   assign d_base  = {bhi_q, blo_q};
   assign d_limit = lim_q;
   assign d_ar    = ar_q;
endmodule

// File: rtl/sdl_desc_cache.sv
module sdl_desc_cache
   import sdl_pkg::*;
#(
   parameter int NUM_SEG = 4,
   localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [SEG_W-1:0]           wr_idx,
   input  logic [SEL_W-1:0]           wr_sel,
   input  logic [DBASE_W-1:0]         wr_base,
   input  logic [DLIM_W-1:0]          wr_limit,
   input  logic [7:0]                 wr_ar,
   input  logic                       inv_en,
   input  logic [SEG_W-1:0]           inv_idx,
   output logic [NUM_SEG-1:0]         valid_o,
   output logic [NUM_SEG*SEL_W-1:0]   sel_o,
   output logic [NUM_SEG*DBASE_W-1:0] base_o,
   output logic [NUM_SEG*DLIM_W-1:0]  limit_o,
   output logic [NUM_SEG*8-1:0]       ar_o
);
   for (genvar i = 0; i < NUM_SEG; i++) begin : g_ent
      logic               v_q;
      logic [SEL_W-1:0]   s_q;
      logic [DBASE_W-1:0] b_q;
      logic [DLIM_W-1:0]  l_q;
      logic [7:0]         a_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            s_q <= '0;
            b_q <= '0;
            l_q <= '0;
            a_q <= '0;
         end else if (inv_en && inv_idx == SEG_W'(i)) begin
            v_q <= 1'b0;
            s_q <= '0;
            b_q <= '0;
            l_q <= '0;
            a_q <= '0;
         end else if (wr_en && wr_idx == SEG_W'(i)) begin
            v_q <= 1'b1;
            s_q <= wr_sel;
            b_q <= wr_base;
            l_q <= wr_limit;
            a_q <= wr_ar;
         end
      end

      assign valid_o[i]                     = v_q;
      assign sel_o[i*SEL_W +: SEL_W]        = s_q;
      assign base_o[i*DBASE_W +: DBASE_W]   = b_q;
      assign limit_o[i*DLIM_W +: DLIM_W]    = l_q;
      assign ar_o[i*8 +: 8]                 = a_q;
   end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
   import sdl_pkg::*;
#(
   parameter int NUM_SEG = 4,
   parameter int ADDR_W  = 24,
   localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_valid,
   output logic                       ld_ready,
   input  logic [15:0]                ld_sel,
   input  logic [SEG_W-1:0]           ld_seg,
   input  logic [1:0]                 cpl,
   input  logic [ADDR_W-1:0]          gdt_base,
   input  logic [15:0]                gdt_limit,
   input  logic [ADDR_W-1:0]          ldt_base,
   input  logic [15:0]                ldt_limit,
   output logic                       mem_req,
   output logic [ADDR_W-1:0]          mem_addr,
   input  logic [15:0]                mem_rdata,
   input  logic                       mem_ack,
   output logic                       done,
   output logic                       fault,
   output logic                       fault_np,
   input  logic [SEG_W-1:0]           use_seg,
   output logic                       use_fault,
   output logic [NUM_SEG-1:0]         seg_valid,
   output logic [NUM_SEG*24-1:0]      seg_base,
   output logic [NUM_SEG*16-1:0]      seg_limit,
   output logic [NUM_SEG*8-1:0]       seg_ar
);
   if (NUM_SEG < 2 || (1 << SEG_W) != NUM_SEG) begin : g_bad_nseg
      $error("NUM_SEG must be a power of two of at least 2");
   end
   if (ADDR_W < DBASE_W) begin : g_bad_addr
      $error("ADDR_W must cover the descriptor base width");
   end

   logic              is_null, over_limit;
   logic [ADDR_W-1:0] desc_addr;
   logic              accept, same_hit, start;
   logic              fsm_busy, fin;
   load_res_t         fin_res;
   logic [DBASE_W-1:0] d_base;
   logic [DLIM_W-1:0]  d_limit;
   acc_byte_t          d_ar;
   logic [SEG_W-1:0]   seg_q;
   logic [SEL_W-1:0]   sel_q;
   logic [NUM_SEG*SEL_W-1:0] sel_flat;
   logic               done_q, fault_q, np_q;

   sdl_sel_decode #(.ADDR_W(ADDR_W)) u_dec (
      .idx        (ld_sel[15:3]),
      .ti         (ld_sel[2]),
      .gdt_base   (gdt_base),
      .gdt_limit  (gdt_limit),
      .ldt_base   (ldt_base),
      .ldt_limit  (ldt_limit),
      .is_null    (is_null),
      .over_limit (over_limit),
      .desc_addr  (desc_addr)
   );

   assign ld_ready = !fsm_busy;
   assign accept   = ld_valid && ld_ready;
   assign same_hit = seg_valid[ld_seg] && (sel_flat[ld_seg*SEL_W +: SEL_W] == ld_sel);
   assign start    = accept && !is_null && !over_limit && !same_hit;

   sdl_fetch_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_addr (desc_addr),
      .start_cpl  (cpl),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rdata  (mem_rdata),
      .mem_ack    (mem_ack),
      .busy       (fsm_busy),
      .fin        (fin),
      .fin_res    (fin_res),
      .d_base     (d_base),
      .d_limit    (d_limit),
      .d_ar       (d_ar)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q   <= '0;
         sel_q   <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         np_q    <= 1'b0;
      end else begin
         if (start) begin
            seg_q <= ld_seg;
            sel_q <= ld_sel;
         end
         done_q  <= (accept && (is_null || over_limit || same_hit)) || fin;
         fault_q <= (accept && !is_null && over_limit) || (fin && fin_res != RES_OK);
         np_q    <= fin && (fin_res == RES_NP);
      end
   end

   sdl_desc_cache #(.NUM_SEG(NUM_SEG)) u_cache (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fin && fin_res == RES_OK),
      .wr_idx   (seg_q),
      .wr_sel   (sel_q),
      .wr_base  (d_base),
      .wr_limit (d_limit),
      .wr_ar    (d_ar),
      .inv_en   (accept && is_null),
      .inv_idx  (ld_seg),
      .valid_o  (seg_valid),
      .sel_o    (sel_flat),
      .base_o   (seg_base),
      .limit_o  (seg_limit),
      .ar_o     (seg_ar)
   );

   assign done      = done_q;
   assign fault     = fault_q;
   assign fault_np  = np_q;
   assign use_fault = !seg_valid[use_seg];
endmodule

// File: rtl/seg_desc_loader_chk.sv
module seg_desc_loader_chk #(
   parameter int NUM_SEG = 4,
   parameter int ADDR_W  = 24
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ld_valid,
   input logic                  ld_ready,
   input logic [15:0]           ld_sel,
   input logic [15:0]           gdt_limit,
   input logic [15:0]           ldt_limit,
   input logic                  mem_req,
   input logic [ADDR_W-1:0]     mem_addr,
   input logic                  mem_ack,
   input logic                  done,
   input logic                  fault,
   input logic                  fault_np,
   input logic [NUM_SEG-1:0]    seg_valid,
   input logic [NUM_SEG*24-1:0] seg_base,
   input logic [NUM_SEG*16-1:0] seg_limit,
   input logic [NUM_SEG*8-1:0]  seg_ar
);
   logic [16:0] end_byte;
   logic        past_limit;
   assign end_byte   = {1'b0, ld_sel[15:3], 3'b000} + 17'd7;
   assign past_limit = end_byte > {1'b0, (ld_sel[2] ? ldt_limit : gdt_limit)};

   a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   a_r12_no_read_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ld_ready);

   a_r4_null_quick: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_ready && ld_sel[15:2] == 14'd0) |=> (done && !fault && !mem_req));

   a_r3_limit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_ready && ld_sel[15:2] != 14'd0 && past_limit)
         |=> (done && fault && !fault_np && !mem_req));

   a_r7_np_is_fault: assert property (@(posedge clk) disable iff (!rst_n)
      fault_np |-> fault);

   a_r8_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);

   a_r9_cache_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(seg_valid) || !$stable(seg_base) || !$stable(seg_limit) || !$stable(seg_ar))
         |-> (done && !fault));
endmodule

bind seg_desc_loader seg_desc_loader_chk #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_seg_desc_loader.sv
module tb_seg_desc_loader;
   localparam int NSEG = 4;
   localparam int AW   = 24;
   localparam logic [AW-1:0] GBASE = 24'h000100;
   localparam logic [AW-1:0] LBASE = 24'h000300;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ld_valid = 1'b0, ld_ready;
   logic [15:0] ld_sel = '0;
   logic [1:0]  ld_seg = '0, use_seg = '0, cpl = '0;
   logic [AW-1:0] gdt_base = GBASE, ldt_base = LBASE;
   logic [15:0] gdt_limit = 16'h003F, ldt_limit = 16'h007F;
   logic mem_req, mem_ack, done, fault, fault_np, use_fault;
   logic [AW-1:0] mem_addr;
   logic [15:0] mem_rdata;
   logic [NSEG-1:0] seg_valid;
   logic [NSEG*24-1:0] seg_base;
   logic [NSEG*16-1:0] seg_limit;
   logic [NSEG*8-1:0]  seg_ar;

   logic [15:0] mem [0:1023];
   logic stall_en = 1'b0, phase = 1'b0;
   int rd_cnt = 0;
   logic [AW-1:0] rd_log [0:3];
   int nchk = 0, nerr = 0;

   always #10 clk = ~clk;

   seg_desc_loader #(.NUM_SEG(NSEG), .ADDR_W(AW)) dut (.*);

   assign mem_ack   = mem_req && (!stall_en || phase);
   assign mem_rdata = mem[mem_addr[10:1]];

   always @(negedge clk) phase <= ~phase;
   always @(posedge clk) begin
      if (mem_req && mem_ack) begin
         rd_log[0] = rd_log[1]; rd_log[1] = rd_log[2]; rd_log[2] = rd_log[3];
         rd_log[3] = mem_addr;
         rd_cnt++;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic put_desc(input logic [AW-1:0] tbl, input int idx, input logic [15:0] lim,
                           input logic [23:0] base, input logic [7:0] ar);
      int w;
      w = int'((tbl + AW'(idx * 8)) >> 1) % 1024;
      mem[w]     = lim;
      mem[w + 1] = base[15:0];
      mem[w + 2] = {ar, base[23:16]};
      mem[w + 3] = 16'hDEAD;
   endtask

   int    l_cyc, l_rd;
   logic  l_f, l_np;

   task automatic run_load(input logic [1:0] seg, input logic [15:0] sel, input logic [1:0] lvl);
      int rd0;
      @(negedge clk);
      ld_valid = 1'b1; ld_sel = sel; ld_seg = seg; cpl = lvl;
      rd0 = rd_cnt;
      @(posedge clk);
      @(negedge clk);
      ld_valid = 1'b0;
      l_cyc = 1;
      while (!done && l_cyc < 40) begin
         @(negedge clk);
         l_cyc++;
      end
      if (!done) chk("load completes", 0, 1);
      l_f = fault; l_np = fault_np; l_rd = rd_cnt - rd0;
   endtask

   task automatic chk_entry(input string req, input int seg, input logic [23:0] b,
                            input logic [15:0] lm, input logic [7:0] ar, input logic v);
      chk(req, seg_valid[seg], v);
      chk(req, seg_base[seg*24 +: 24], b);
      chk(req, seg_limit[seg*16 +: 16], lm);
      chk(req, seg_ar[seg*8 +: 8], ar);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 valid", seg_valid, 0);
      chk("R11 base", seg_base, 0);
      chk("R11 done/fault", {done, fault, fault_np}, 0);
      chk("R11 mem_req", mem_req, 0);
      chk("R11 ld_ready", ld_ready, 1);

      // R1 R2 R8: global entry 1, requester bits set but ignored
      put_desc(GBASE, 1, 16'h0FFF, 24'h123456, 8'hF2);
      run_load(2'd0, 16'h000B, 2'd0);
      chk("R8 fault", {l_f, l_np}, 0);
      chk("R2 reads", l_rd, 4);
      for (int k = 0; k < 4; k++) chk("R1 R2 read address", rd_log[k], GBASE + 8 + 2 * k);
      chk_entry("R8 entry", 0, 24'h123456, 16'h0FFF, 8'hF2, 1'b1);

      // R10 same selector: memory changed, no refetch
      put_desc(GBASE, 1, 16'h0001, 24'h000001, 8'hF2);
      run_load(2'd0, 16'h000B, 2'd0);
      chk("R10 cycles", l_cyc, 1);
      chk("R10 reads", l_rd, 0);
      chk("R10 fault", l_f, 0);
      chk_entry("R10 entry", 0, 24'h123456, 16'h0FFF, 8'hF2, 1'b1);

      // R6 R9 privilege fault keeps old entry
      put_desc(GBASE, 2, 16'h00AA, 24'h0A0A0A, 8'h92);
      run_load(2'd0, 16'h0010, 2'd3);
      chk("R6 fault", {l_f, l_np}, 2'b10);
      chk_entry("R9 entry kept", 0, 24'h123456, 16'h0FFF, 8'hF2, 1'b1);

      // R1 R2 local table with stalled reads
      stall_en = 1'b1;
      put_desc(LBASE, 3, 16'h4321, 24'hABCDEF, 8'h93);
      run_load(2'd1, 16'h001C, 2'd0);
      stall_en = 1'b0;
      chk("R2 stalled fault", l_f, 0);
      for (int k = 0; k < 4; k++) chk("R1 local address", rd_log[k], LBASE + 24 + 2 * k);
      chk_entry("R1 local entry", 1, 24'hABCDEF, 16'h4321, 8'h93, 1'b1);

      // R3 limit edges
      put_desc(LBASE, 15, 16'h0015, 24'h151515, 8'h92);
      run_load(2'd2, 16'h007C, 2'd0);
      chk("R3 last local fits", {l_f, l_rd}, {1'b0, 32'd4});
      run_load(2'd2, 16'h0084, 2'd0);
      chk("R3 local over", {l_f, l_np}, 2'b10);
      chk("R3 local no read", l_rd, 0);
      chk("R3 local cycles", l_cyc, 1);
      put_desc(GBASE, 7, 16'h0007, 24'h070707, 8'h92);
      run_load(2'd3, 16'h0038, 2'd0);
      chk("R3 last global fits", l_f, 0);
      run_load(2'd3, 16'h0040, 2'd0);
      chk("R3 global over", {l_f, l_rd}, {1'b1, 32'd0});
      chk_entry("R9 after limit", 3, 24'h070707, 16'h0007, 8'h92, 1'b1);

      // R4 null selector with requester bits
      run_load(2'd1, 16'h0003, 2'd2);
      chk("R4 cycles", l_cyc, 1);
      chk("R4 fault/reads", {l_f, l_rd}, {1'b0, 32'd0});
      chk("R4 valid", seg_valid[1], 0);
      use_seg = 2'd1; #1;
      chk("R4 use_fault", use_fault, 1);
      use_seg = 2'd0; #1;
      chk("R4 use_fault other", use_fault, 0);
      // local entry 0 is not null
      put_desc(LBASE, 0, 16'h0100, 24'h202020, 8'h92);
      run_load(2'd1, 16'h0004, 2'd0);
      chk("R4 local zero loads", {l_f, l_rd}, {1'b0, 32'd4});
      chk_entry("R4 local zero entry", 1, 24'h202020, 16'h0100, 8'h92, 1'b1);

      // R12 request held during a stalled fetch is ignored
      run_load(2'd3, 16'h0000, 2'd0);
      stall_en = 1'b1;
      put_desc(GBASE, 3, 16'h0333, 24'h333333, 8'h92);
      @(negedge clk);
      ld_valid = 1'b1; ld_sel = 16'h0018; ld_seg = 2'd2; cpl = 2'd0;
      @(posedge clk);
      @(negedge clk);
      ld_sel = 16'h0008; ld_seg = 2'd3;
      chk("R12 ld_ready low", ld_ready, 0);
      begin
         int n = 0;
         while (!done && n < 40) begin @(negedge clk); n++; end
      end
      ld_valid = 1'b0;
      stall_en = 1'b0;
      chk("R12 first load", fault, 0);
      chk_entry("R12 target", 2, 24'h333333, 16'h0333, 8'h92, 1'b1);
      @(negedge clk);
      chk("R12 second ignored", seg_valid[3], 0);

      // R5 R6 R7 R8 sweep over access byte patterns and levels
      for (int k = 0; k < 512; k++) begin
         logic       p, s, gp, ok;
         logic [1:0] dpl, lvl;
         logic [2:0] t;
         logic [7:0] ar;
         logic [23:0] b;
         logic [15:0] lm;
         int idx, sg;
         t = k[2:0]; s = k[3]; p = k[4]; dpl = k[6:5]; lvl = k[8:7];
         ar  = {p, dpl, s, t, 1'b0};
         idx = 1 + (k % 14);
         sg  = k % NSEG;
         b   = 24'h010000 + 24'(k * 24'h000357);
         lm  = 16'h1000 + 16'(k);
         gp  = !s || (t[2] && !t[0]) || (dpl < lvl);
         ok  = !gp && p;
         put_desc(LBASE, idx, lm, b, ar);
         run_load(2'(sg), 16'h0000, 2'd0);
         run_load(2'(sg), 16'(idx * 8 + 4), lvl);
         chk("R5 R6 R7 fault", l_f, !ok);
         chk("R7 not-present flag", l_np, !gp && !p);
         chk("R2 sweep reads", l_rd, 4);
         use_seg = 2'(sg); #1;
         chk("R8 use_fault", use_fault, !ok);
         if (ok) chk_entry("R8 sweep entry", sg, b, lm, ar, 1'b1);
         else chk("R9 sweep entry", seg_valid[sg], 0);
      end

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule